// File: doc/BRIEF.md
# Crypto Engine Interrupt Aggregator

This block gathers completion and fault events from five cryptographic engines (AES, TDES/DES, PRNG, ECC and SHA) into one word of sticky flags and raises a single level interrupt line toward the processor. Each engine has a done flag. Four of them (all but the PRNG) also have an error flag, which gathers that engine's operating faults and its setting faults into one bit. Each flag sets on its event and stays set until software writes a 1 to it.

For every engine, a DMA-mode select input picks the source of the done event. With DMA mode off, the engine's own finish pulse sets the flag. With DMA mode on, the pulse that reports the programmed DMA count as fully fed into the engine sets the flag, and the finish pulse is ignored. A small register port gives access to an enable word and the flag word. The interrupt line is the OR of every flag that is set and whose enable bit is also set.

Flag and enable bits share the same positions in both words. The positions are fixed and sparse, so that existing software can decode them.

Top module: `crypto_irq_agg`

## Requirements
- R1: After reset, the enable word (offset 0x0) and the flag word (offset 0x4) both read 0, and `irq` is low.
- R2: A write to offset 0x0 loads the enable word. Only the implemented bits hold a value: 0,1,8,9,16,22,23,24,25 (mask 0x03C10303). Every other bit reads 0.
- R3: With DMA mode off for an engine, a pulse on its `eng_done` bit sets its done flag from the next cycle. The done flag positions are: AES bit 0, TDES bit 8, PRNG bit 16, ECC bit 22, SHA bit 24. The engine index order on the vector ports is AES=0, TDES=1, PRNG=2, ECC=3, SHA=4.
- R4: With DMA mode on for an engine, a pulse on its `dma_cnt_hit` bit sets its done flag from the next cycle, and its `eng_done` pulse has no effect. With DMA mode off, `dma_cnt_hit` has no effect.
- R5: A pulse on `eng_err` sets the matching error flag from the next cycle. The `eng_err` index order is AES=0, TDES=1, ECC=2, SHA=3, and the flag positions are bits 1, 9, 23 and 25. The PRNG has no error flag.
- R6: Writing to offset 0x4 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R7: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: Flags set whatever their enable bit holds, so software can poll them with the interrupt masked.
- R9: `irq` is high exactly while at least one flag is set and has its enable bit set. It stays high until such flags are cleared or disabled.
- R10: Unimplemented flag bits read 0 and cannot be set. Reads from any other offset return 0. Writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_done | input | 5 | Engine finish pulses, index AES,TDES,PRNG,ECC,SHA |
| dma_mode | input | 5 | Per-engine DMA mode select |
| dma_cnt_hit | input | 5 | Per-engine DMA count-reached pulses |
| eng_err | input | 4 | Error pulses, index AES,TDES,ECC,SHA |
| irq | output | 1 | Level interrupt request |

## Verification
The clocked properties treat any event input that is high at an edge as a request to set the flag. They predict a clear only in a cycle where no source feeds that flag, and they take `dma_mode` as sampled in the same cycle as the pulse it qualifies. The bench changes every input one time unit after a rising edge and holds it for exactly one cycle, so that a select change and a pulse are never ambiguous at an edge. Its accesses use only the word offsets 0x0, 0x4 and 0x8, and it drives simultaneous set and clear only in the dedicated collision scenario.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_ENG  = 5;
    localparam int NUM_ERR  = 4;
    localparam int NUM_FLAG = 9;

    // compact flag index -> bit position in the enable/flag words
    localparam int FLAG_POS [NUM_FLAG] = '{0, 1, 8, 9, 16, 22, 23, 24, 25};
    // engine index -> compact index of its done flag
    localparam int DONE_IDX [NUM_ENG]  = '{0, 2, 4, 5, 7};
    // error source index -> compact index of its error flag
    localparam int ERR_IDX  [NUM_ERR]  = '{1, 3, 6, 8};

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ENABLE,
        TGT_FLAG
    } reg_tgt_e;

    function automatic logic [DATA_W-1:0] impl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int f = 0; f < NUM_FLAG; f++) m[FLAG_POS[f]] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] spread(input logic [NUM_FLAG-1:0] c);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int f = 0; f < NUM_FLAG; f++) w[FLAG_POS[f]] = c[f];
        return w;
    endfunction
endpackage

// File: rtl/cirq_done_sel.sv
module cirq_done_sel #(
    parameter int N = 5
) (
    input  logic [N-1:0] finish_i,
    input  logic [N-1:0] dma_mode_i,
    input  logic [N-1:0] cnt_hit_i,
    output logic [N-1:0] done_evt_o
);
    for (genvar e = 0; e < N; e++) begin : g_sel
        assign done_evt_o[e] = dma_mode_i[e] ? cnt_hit_i[e] : finish_i[e];
    end
endmodule

// File: rtl/cirq_flag_bit.sv
module cirq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;   // set has priority over clear
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/cirq_regfile.sv
module cirq_regfile
    import cirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int EN_OFS   = 0,
    parameter int FLAG_OFS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_FLAG-1:0] flag_i,
    output logic [NUM_FLAG-1:0] en_o,
    output logic [NUM_FLAG-1:0] clr_o,
    output logic [DATA_W-1:0]   bus_rdata
);
    localparam logic [DATA_W-1:0] MASK = impl_mask();

    reg_tgt_e          tgt;
    logic [NUM_FLAG-1:0] wbits;
    logic              unused_wbits;

    assign unused_wbits = ^(bus_wdata & ~MASK);

    always_comb begin
        tgt = TGT_NONE;
        if (bus_addr == ADDR_W'(EN_OFS))        tgt = TGT_ENABLE;
        else if (bus_addr == ADDR_W'(FLAG_OFS)) tgt = TGT_FLAG;
    end

    always_comb begin
        for (int f = 0; f < NUM_FLAG; f++) wbits[f] = bus_wdata[FLAG_POS[f]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             en_o <= '0;
        else if (bus_wr && tgt == TGT_ENABLE)   en_o <= wbits;
    end

    assign clr_o = (bus_wr && tgt == TGT_FLAG) ? wbits : '0;

    always_comb begin
        unique case (tgt)
            TGT_ENABLE: bus_rdata = spread(en_o);
            TGT_FLAG:   bus_rdata = spread(flag_i);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/crypto_irq_agg.sv
module crypto_irq_agg
    import cirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int EN_OFS   = 0,
    parameter int FLAG_OFS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [4:0]         eng_done,
    input  logic [4:0]         dma_mode,
    input  logic [4:0]         dma_cnt_hit,
    input  logic [3:0]         eng_err,
    output logic               irq
);
    logic [NUM_ENG-1:0]  done_evt;
    logic [NUM_FLAG-1:0] set_c;
    logic [NUM_FLAG-1:0] clr_c;
    logic [NUM_FLAG-1:0] flag_c;
    logic [NUM_FLAG-1:0] en_c;

    cirq_done_sel #(.N(NUM_ENG)) u_sel (
        .finish_i   (eng_done),
        .dma_mode_i (dma_mode),
        .cnt_hit_i  (dma_cnt_hit),
        .done_evt_o (done_evt)
    );

    always_comb begin
        set_c = '0;
        for (int e = 0; e < NUM_ENG; e++) set_c[DONE_IDX[e]] = done_evt[e];
        for (int k = 0; k < NUM_ERR; k++) set_c[ERR_IDX[k]]  = eng_err[k];
    end

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        cirq_flag_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_c[f]),
            .clr_i (clr_c[f]),
            .q_o   (flag_c[f])
        );
    end

    cirq_regfile #(
        .ADDR_W   (ADDR_W),
        .EN_OFS   (EN_OFS),
        .FLAG_OFS (FLAG_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag_i    (flag_c),
        .en_o      (en_c),
        .clr_o     (clr_c),
        .bus_rdata (bus_rdata)
    );

    assign irq = |(flag_c & en_c);
endmodule

// File: rtl/crypto_irq_agg_chk.sv
module crypto_irq_agg_chk
    import cirq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int EN_OFS   = 0,
    parameter int FLAG_OFS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [4:0]          eng_done,
    input logic [4:0]          dma_mode,
    input logic [4:0]          dma_cnt_hit,
    input logic [3:0]          eng_err,
    input logic [NUM_FLAG-1:0] flag_c,
    input logic [NUM_FLAG-1:0] en_c,
    input logic                irq
);
    logic [NUM_FLAG-1:0] src_any;
    logic                wr_flag;
    logic                wr_en;

    assign wr_flag = bus_wr && (bus_addr == ADDR_W'(FLAG_OFS));
    assign wr_en   = bus_wr && (bus_addr == ADDR_W'(EN_OFS));

    always_comb begin
        src_any = '0;
        for (int e = 0; e < NUM_ENG; e++)
            src_any[DONE_IDX[e]] = eng_done[e] | dma_cnt_hit[e];
        for (int k = 0; k < NUM_ERR; k++)
            src_any[ERR_IDX[k]] = eng_err[k];
    end

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        // R3 and R7: finish pulse in non-DMA mode sets the done flag, even against a clear
        p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!dma_mode[e] && eng_done[e]) |=> flag_c[DONE_IDX[e]]);
        // R4: count-reached pulse in DMA mode sets the done flag
        p_dma_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (dma_mode[e] && dma_cnt_hit[e]) |=> flag_c[DONE_IDX[e]]);
    end

    for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
        p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err[k] |=> flag_c[ERR_IDX[k]]);
    end

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_bit
        p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flag && bus_wdata[FLAG_POS[f]] && !src_any[f]) |=> !flag_c[f]);
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_any[f] && !(wr_flag && bus_wdata[FLAG_POS[f]])) |=> $stable(flag_c[f]));
        p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (en_c[f] == $past(bus_wdata[FLAG_POS[f]])));
    end

    // R9: no enable bit set means no interrupt
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c == '0) |-> !irq);
endmodule

bind crypto_irq_agg crypto_irq_agg_chk #(
    .ADDR_W   (ADDR_W),
    .EN_OFS   (EN_OFS),
    .FLAG_OFS (FLAG_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .eng_done    (eng_done),
    .dma_mode    (dma_mode),
    .dma_cnt_hit (dma_cnt_hit),
    .eng_err     (eng_err),
    .flag_c      (flag_c),
    .en_c        (en_c),
    .irq         (irq)
);

// File: tb/crypto_irq_agg_bench.sv
`timescale 1ns/1ps
module crypto_irq_agg_bench;
    localparam logic [31:0] ALL_BITS  = 32'h03C1_0303;
    localparam logic [31:0] DONE_BITS = 32'h0141_0101;
    localparam logic [31:0] ERR_BITS  = 32'h0280_0202;
    localparam int          DONE_AT [5] = '{0, 8, 16, 22, 24};
    localparam int          ERR_AT  [4] = '{1, 9, 23, 25};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  eng_done = '0;
    logic [4:0]  dma_mode = '0;
    logic [4:0]  dma_cnt_hit = '0;
    logic [3:0]  eng_err = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    crypto_irq_agg u_crypto_irq_agg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .dma_mode(dma_mode), .dma_cnt_hit(dma_cnt_hit), .eng_err(eng_err), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [4:0] dn, input logic [4:0] hit, input logic [3:0] er);
        eng_done = dn; dma_cnt_hit = hit; eng_err = er;
        step();
        eng_done = '0; dma_cnt_hit = '0; eng_err = '0;
    endtask

    task automatic clear_all();
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 enable after reset", v, 32'h0);
        rd(8'h04, v); check("R1 flags after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 enable all ones", v, ALL_BITS);
        wr(8'h00, 32'h0000_0101); rd(8'h00, v); check("R2 enable pattern", v, 32'h0000_0101);
        wr(8'h00, 32'h0000_0000); rd(8'h00, v); check("R2 enable zero", v, 32'h0);
    endtask

    task automatic t_done_nondma();
        logic [31:0] v;
        logic [31:0] exp;
        dma_mode = '0;
        exp = '0;
        for (int e = 0; e < 5; e++) begin
            pulse(5'(1 << e), '0, '0);
            exp[DONE_AT[e]] = 1'b1;
            rd(8'h04, v); check("R3 done flag from finish", v, exp);
        end
        clear_all();
    endtask

    task automatic t_done_dma();
        logic [31:0] v;
        dma_mode = 5'h1F;
        pulse(5'h1F, '0, '0);
        rd(8'h04, v); check("R4 finish ignored in DMA mode", v, 32'h0);
        pulse('0, 5'h1F, '0);
        rd(8'h04, v); check("R4 count-reached sets done", v, DONE_BITS);
        clear_all();
        dma_mode = 5'h00;
        pulse('0, 5'h1F, '0);
        rd(8'h04, v); check("R4 count-reached ignored in non-DMA mode", v, 32'h0);
        dma_mode = 5'b00010;
        pulse(5'b00001, 5'b00010, '0);
        rd(8'h04, v); check("R4 mixed per-engine select", v, 32'h0000_0101);
        dma_mode = '0;
        clear_all();
    endtask

    task automatic t_err();
        logic [31:0] v;
        logic [31:0] exp;
        exp = '0;
        for (int k = 0; k < 4; k++) begin
            pulse('0, '0, 4'(1 << k));
            exp[ERR_AT[k]] = 1'b1;
            rd(8'h04, v); check("R5 error flag", v, exp);
        end
        check("R5 all error positions", v, ERR_BITS);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(5'h1F, '0, 4'hF);
        rd(8'h04, v); check("R6 all flags set", v, ALL_BITS);
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, v); check("R6 write zero keeps flags", v, ALL_BITS);
        wr(8'h04, 32'h0000_0102);
        rd(8'h04, v); check("R6 selective clear", v, 32'h03C1_0201);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); check("R6 clear all", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(5'b00011, '0, '0);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0101; eng_done = 5'b00001;
        step();
        bus_wr = 1'b0; bus_wdata = '0; eng_done = '0;
        rd(8'h04, v); check("R7 set beats clear", v, 32'h0000_0001);
        clear_all();
    endtask

    task automatic t_poll();
        logic [31:0] v;
        wr(8'h00, 32'h0);
        pulse(5'b10000, '0, '0);
        rd(8'h04, v); check("R8 flag sets while disabled", v, 32'h0100_0000);
        check("R8 irq stays low while disabled", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_irq();
        wr(8'h00, 32'h0000_0100);
        pulse(5'b01000, '0, '0);
        check("R9 disabled flag gives no irq", {31'b0, irq}, 32'h0);
        pulse(5'b00010, '0, '0);
        check("R9 enabled flag raises irq", {31'b0, irq}, 32'h1);
        step(); step(); step();
        check("R9 irq holds as a level", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h0000_0100);
        check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
        pulse(5'b00010, '0, '0);
        check("R9 irq raised again", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0);
        check("R9 irq drops when disabled", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0001);
        pulse(5'b00001, '0, '0);
        rd(8'h08, v); check("R10 other offset reads zero", v, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R10 other offset write keeps enable", v, 32'h0000_0001);
        rd(8'h04, v); check("R10 other offset write keeps flags", v, 32'h0000_0001);
        wr(8'h00, ~ALL_BITS);
        rd(8'h00, v); check("R10 unused enable bits read zero", v, 32'h0);
        pulse(5'h1F, '0, 4'hF);
        rd(8'h04, v); check("R10 unused flag bits stay zero", v & ~ALL_BITS, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enable_rw();
        t_done_nondma();
        t_done_dma();
        t_err();
        t_w1c();
        t_set_wins();
        t_poll();
        t_irq();
        t_unused();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule